// File: doc/BRIEF.md
# Flow Signature Hash Engine

This block turns a pair of 32-bit flow descriptors into one 32-bit filter hash word. A flow-steering table uses that word to place and later recognise a flow. The first operand is the uncompressed flow word, which carries pool, flow-class and VLAN identifiers. The second operand is the compressed word, built upstream by XOR-folding the addresses and ports of the flow. Two keyed XOR hashes run side by side over a stream built from these operands: a bucket hash and a signature hash. A third partial result gathers the key bits that both keys have set, and it is shared between the two.

The stream has two 32-bit halves. The high half is the compressed word after it has been mixed with the flow word. The low half is the compressed word with its two 16-bit halves exchanged. The flow word enters the low half only after iteration 0, so the lowest stream bit carries no flow mixing. The engine then folds the shared term into both hashes and masks each hash to 15 bits. The bucket hash lands in bits 14:0 and the signature in bits 30:16. Bit 15 is forced to one to mark the bucket as valid.

The hash itself is purely combinational. A two-state output controller registers the result. The controller has two states:
- `ST_IDLE`: no result is presented.
- `ST_OUT`: a result is presented.

It has three transitions:
- *accept*: from `ST_IDLE` to `ST_OUT` when `in_valid` is high.
- *stream*: from `ST_OUT` to `ST_OUT` while `in_valid` stays high.
- *drain*: from `ST_OUT` to `ST_IDLE` when `in_valid` is low.

Top module: `flow_sig_hash`

## Requirements
- R1: While `rst` is high at a rising edge, after that edge `out_valid` is 0 and `out_hash` is 0x00000000.
- R2: `out_valid` is 1 in exactly the cycle after each cycle with `in_valid` high, and 0 after a cycle with `in_valid` low. Every accepted pair yields exactly one result, in order, including back-to-back inputs.
- R3: Whenever `out_valid` is 1, bit 15 of `out_hash` is 1.
- R4: Whenever `out_valid` is 1, bit 31 of `out_hash` is 0.
- R5: `out_hash` equals the keyed hash of the accepted pair. The bucket key is 0x3DAD14E2, the signature key is 0x174D3614 and the shared key is their AND.
  - In iteration n (0..15), key bit n applies the low half and key bit n+16 applies the high half. The priority is shared, then bucket, then signature.
  - A shared or bucket hit XORs in the half shifted right by n. A signature-only hit XORs in the half shifted left by 16-n.
  - At the end, the shared term is XORed into the bucket, which keeps bits 14:0. The shared term shifted left 16 is XORed into the signature, which keeps bits 30:16. The two are combined by XOR.
- R6: An all-zero pair gives 0x00008000.
- R7: The high half is the compressed word XOR flow XOR (flow >> 16), applied before iteration 0. The low half is the halves-swapped compressed word. It is XORed with flow and (flow << 16) only from iteration 1 on.
- R8: After a cycle with `in_valid` low, `out_hash` keeps the value it had.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair present this cycle |
| in_flow_word | input | 32 | Uncompressed flow word (pool, class, VLAN) |
| in_comp_word | input | 32 | Compressed address/port word |
| out_valid | output | 1 | Result present this cycle |
| out_hash | output | 32 | Signature (30:16), valid flag (15), bucket (14:0) |

## Verification
The checker watches the timing and format on every cycle:
- the one-cycle latency from `in_valid` to `out_valid`;
- the reset clearing;
- the forced valid flag and the cleared top bit while a result is shown;
- the hold of `out_hash` during idle cycles.

The hash values themselves (R5, R6, R7) can only be shown by the bench's scenarios. These compare each result against an independent loop model over random pairs, the all-zero and all-one pairs, and pairs that differ only in the flow word. Those scenarios also show that back-to-back results keep their order.

// File: rtl/fsh_pkg.sv
package fsh_pkg;

    localparam int WORD_W    = 32;
    localparam int HALF_W    = WORD_W / 2;
    localparam int FIELD_W   = HALF_W - 1;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t shared_acc;
        word_t bucket_acc;
        word_t sig_acc;
    } acc_t;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_OUT  = 1'b1
    } out_state_e;

    localparam word_t FIELD_MASK = word_t'((1 << FIELD_W) - 1);
    localparam word_t VALID_FLAG = word_t'(1) << FIELD_W;

endpackage

// File: rtl/fsh_stream_prep.sv
module fsh_stream_prep
    import fsh_pkg::*;
(
    input  word_t flow_word,
    input  word_t comp_word,
    output word_t hi_word,
    output word_t lo_first,
    output word_t lo_rest
);

    word_t swapped;

    // Low half of the stream: compressed word with 16-bit halves exchanged.
    assign swapped  = {comp_word[HALF_W-1:0], comp_word[WORD_W-1:HALF_W]};

    // High half takes the flow word before any iteration.
    assign hi_word  = comp_word ^ flow_word ^ (flow_word >> HALF_W);

    // Iteration 0 sees the unmixed low half; later iterations the mixed one.
    assign lo_first = swapped;
    assign lo_rest  = swapped ^ flow_word ^ (flow_word << HALF_W);

endmodule

// File: rtl/fsh_key_lane.sv
module fsh_key_lane
    import fsh_pkg::*;
#(
    parameter logic [31:0] BUCKET_KEY = 32'h3DAD14E2,
    parameter logic [31:0] SIG_KEY    = 32'h174D3614
)
(
    input  word_t hi_word,
    input  word_t lo_first,
    input  word_t lo_rest,
    output acc_t  acc
);

    localparam logic [31:0] SHARED_KEY = BUCKET_KEY & SIG_KEY;

    word_t term_sh [HALF_W];
    word_t term_bk [HALF_W];
    word_t term_sg [HALF_W];

    for (genvar n = 0; n < HALF_W; n++) begin : g_iter
        // Priority per key bit: shared, then bucket, then signature.
        localparam bit LO_SH = SHARED_KEY[n];
        localparam bit LO_BK = !LO_SH && BUCKET_KEY[n];
        localparam bit LO_SG = !LO_SH && !LO_BK && SIG_KEY[n];
        localparam bit HI_SH = SHARED_KEY[n+HALF_W];
        localparam bit HI_BK = !HI_SH && BUCKET_KEY[n+HALF_W];
        localparam bit HI_SG = !HI_SH && !HI_BK && SIG_KEY[n+HALF_W];

        word_t lo_w;
        if (n == 0) begin : g_first
            assign lo_w = lo_first;
        end else begin : g_rest
            assign lo_w = lo_rest;
        end

        assign term_sh[n] = (LO_SH ? (lo_w >> n) : '0)
                          ^ (HI_SH ? (hi_word >> n) : '0);
        assign term_bk[n] = (LO_BK ? (lo_w >> n) : '0)
                          ^ (HI_BK ? (hi_word >> n) : '0);
        assign term_sg[n] = (LO_SG ? (lo_w << (HALF_W - n)) : '0)
                          ^ (HI_SG ? (hi_word << (HALF_W - n)) : '0);
    end

    always_comb begin
        acc = '0;
        for (int n = 0; n < HALF_W; n++) begin
            acc.shared_acc = acc.shared_acc ^ term_sh[n];
            acc.bucket_acc = acc.bucket_acc ^ term_bk[n];
            acc.sig_acc    = acc.sig_acc    ^ term_sg[n];
        end
    end

endmodule

// File: rtl/fsh_combine.sv
module fsh_combine
    import fsh_pkg::*;
(
    input  acc_t  acc,
    output word_t hash_word
);

    word_t bucket_fin;
    word_t sig_fin;

    assign bucket_fin = (acc.bucket_acc ^ acc.shared_acc) & FIELD_MASK;
    assign sig_fin    = (acc.sig_acc ^ (acc.shared_acc << HALF_W))
                      & (FIELD_MASK << HALF_W);
    assign hash_word  = sig_fin ^ bucket_fin ^ VALID_FLAG;

endmodule

// File: rtl/flow_sig_hash.sv
module flow_sig_hash
    import fsh_pkg::*;
#(
    parameter logic [31:0] BUCKET_KEY = 32'h3DAD14E2,
    parameter logic [31:0] SIG_KEY    = 32'h174D3614
)
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [31:0] in_flow_word,
    input  logic [31:0] in_comp_word,
    output logic        out_valid,
    output logic [31:0] out_hash
);

    word_t      hi_word;
    word_t      lo_first;
    word_t      lo_rest;
    acc_t       acc;
    word_t      hash_next;
    word_t      hash_q;
    out_state_e state_q;
    out_state_e state_d;

    fsh_stream_prep u_prep (
        .flow_word (in_flow_word),
        .comp_word (in_comp_word),
        .hi_word   (hi_word),
        .lo_first  (lo_first),
        .lo_rest   (lo_rest)
    );

    fsh_key_lane #(
        .BUCKET_KEY (BUCKET_KEY),
        .SIG_KEY    (SIG_KEY)
    ) u_lane (
        .hi_word  (hi_word),
        .lo_first (lo_first),
        .lo_rest  (lo_rest),
        .acc      (acc)
    );

    fsh_combine u_comb (
        .acc       (acc),
        .hash_word (hash_next)
    );

    // Next-state logic: accept, stream, drain.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid)  state_d = ST_OUT;
            ST_OUT:  if (!in_valid) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Output register: loads on every accepted pair, holds otherwise.
    always_ff @(posedge clk) begin
        if (rst)           hash_q <= '0;
        else if (in_valid) hash_q <= hash_next;
    end

    assign out_valid = (state_q == ST_OUT);
    assign out_hash  = hash_q;

endmodule

// File: rtl/fsh_checker.sv
module fsh_checker (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        out_valid,
    input logic [31:0] out_hash
);

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!out_valid && out_hash == 32'h0));

    a_r2_latency: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r3_valid_flag: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_hash[15]);

    a_r4_top_clear: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !out_hash[31]);

    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_hash));

endmodule

bind flow_sig_hash fsh_checker u_fsh_checker (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_hash  (out_hash)
);

// File: tb/flow_sig_hash_tb_top.sv
module flow_sig_hash_tb_top;

    localparam logic [31:0] K_BUCKET = 32'h3DAD14E2;
    localparam logic [31:0] K_SIG    = 32'h174D3614;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_flow_word = '0;
    logic [31:0] in_comp_word = '0;
    logic        out_valid;
    logic [31:0] out_hash;

    int checks = 0;
    int fails  = 0;
    int cycle  = 0;
    bit done   = 1'b0;

    logic [31:0] exp_q [$];
    int          cyc_q [$];
    string       tag_q [$];
    logic [31:0] last_exp = '0;

    always #4 clk = ~clk;
    always @(posedge clk) cycle <= cycle + 1;

    flow_sig_hash dut_i (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_flow_word (in_flow_word),
        .in_comp_word (in_comp_word),
        .out_valid    (out_valid),
        .out_hash     (out_hash)
    );

    // Behavioural model written straight from the requirements.
    function automatic logic [31:0] model(logic [31:0] flow, logic [31:0] comp);
        logic [31:0] kc, hi, lo, c, b, s;
        kc = K_BUCKET & K_SIG;
        hi = comp ^ flow ^ (flow >> 16);
        lo = {comp[15:0], comp[31:16]};
        c = '0; b = '0; s = '0;
        for (int n = 0; n < 16; n++) begin
            if (n == 1) lo = lo ^ flow ^ (flow << 16);
            if (kc[n])            c = c ^ (lo >> n);
            else if (K_BUCKET[n]) b = b ^ (lo >> n);
            else if (K_SIG[n])    s = s ^ (lo << (16 - n));
            if (kc[n+16])            c = c ^ (hi >> n);
            else if (K_BUCKET[n+16]) b = b ^ (hi >> n);
            else if (K_SIG[n+16])    s = s ^ (hi << (16 - n));
        end
        b = (b ^ c) & 32'h0000_7FFF;
        s = (s ^ (c << 16)) & 32'h7FFF_0000;
        return s ^ b ^ 32'h0000_8000;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic send(logic [31:0] flow, logic [31:0] comp, string tag);
        @(negedge clk);
        in_valid     = 1'b1;
        in_flow_word = flow;
        in_comp_word = comp;
        last_exp     = model(flow, comp);
        exp_q.push_back(last_exp);
        cyc_q.push_back(cycle);
        tag_q.push_back(tag);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: pops the scoreboard as results appear.
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                check("R2 unexpected result", 32'(out_valid), 32'h0);
            end else begin
                logic [31:0] e;
                int          c;
                string       t;
                e = exp_q.pop_front();
                c = cyc_q.pop_front();
                t = tag_q.pop_front();
                check("R2 latency", 32'(cycle), 32'(c + 1));
                check(t, out_hash, e);
                check("R3 valid flag", 32'(out_hash[15]), 32'h1);
                check("R4 top bit", 32'(out_hash[31]), 32'h0);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 out_valid", 32'(out_valid), 32'h0);
        check("R1 out_hash", out_hash, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        idle(2);
        check("R2 idle valid", 32'(out_valid), 32'h0);

        // R6: all-zero pair, fixed expected value
        send(32'h0, 32'h0, "R6 zero pair");
        idle(1);
        check("R6 constant", out_hash, 32'h0000_8000);

        // R5: all-ones pair
        send(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5 ones pair");
        idle(3);
        // R8: hash held while idle
        check("R8 hold", out_hash, last_exp);
        check("R2 drained", 32'(out_valid), 32'h0);

        // R7: flow word alone, and single low bits that probe iteration 0
        send(32'h0000_0001, 32'h0, "R7 flow bit0");
        send(32'h0001_0000, 32'h0, "R7 flow bit16");
        send(32'h1234_5678, 32'h0, "R7 flow only");
        send(32'h0, 32'h0001_0000, "R7 comp bit16");
        send(32'hA5A5_0000, 32'h0000_C3C3, "R7 mixed");
        idle(2);

        // R5/R2: back-to-back random stream
        for (int i = 0; i < 1000; i++) begin
            send($urandom(), $urandom(), "R5 random");
            if (i % 97 == 0) idle(1 + (i % 3));
        end
        idle(4);
        check("R8 hold after stream", out_hash, last_exp);
        check("R2 all results seen", 32'(exp_q.size()), 32'h0);

        // R1: reset after activity clears the output
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", 32'(out_valid), 32'h0);
        check("R1 hash after reset", out_hash, 32'h0);
        rst = 1'b0;
        idle(2);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=%0d expected=<%0d cycles", cycle, 200000);
            $display("  test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

endmodule